// File: doc/BRIEF.md
# APB Read Requester with Handshake-Gated Capture

This block is the requesting side of an APB read. A local client presents an address with `req_valid`. The block takes the request only while it is idle. It then drives one setup cycle on the bus, followed by an access phase that lasts until the responder raises `pready`. The block keeps `pwrite` low for the whole transfer. It holds `paddr` fixed from setup through the final cycle. It keeps `psel` and `penable` asserted through every wait cycle.

The read value is loaded into a result register on one clock edge only. That edge is the one where select, enable and ready are all high and write is low. On every other cycle the read data bus is ignored, including wait cycles, where `penable` is already high and the responder may be driving anything. After the completing edge the block returns to idle. For one cycle it raises `rd_done`, with the loaded value on `rd_data`.

The block has three states. IDLE is the only state in which a request is taken. SETUP asserts select without enable and always lasts exactly one cycle. ACCESS asserts select and enable, and the block stays there while `pready` is low. The transitions are:
- IDLE to SETUP on an accepted request.
- SETUP to ACCESS unconditionally.
- ACCESS to ACCESS while the responder waits.
- ACCESS to IDLE on completion.

Top module: `apb_rd_capture`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `psel`, `penable`, `rd_done` and `rd_data` are all zero, and the block is in IDLE with `req_ready` high.
- R2: `req_ready` is high only in IDLE. A `req_valid` seen at a clock edge outside IDLE is ignored and does not change the address or the sequence of the transfer in progress.
- R3: On the edge after an accepted request, the block enters SETUP. There `psel` is 1 and `penable` is 0 for exactly one cycle, and the next cycle is ACCESS.
- R4: In ACCESS, `psel` and `penable` are both 1 and stay 1 on every cycle in which `pready` is sampled low.
- R5: `paddr` equals the accepted request address on every cycle from SETUP through the completion cycle, and `pwrite` is 0 on every cycle.
- R6: `rd_data` loads `prdata` only at an edge where `psel`, `penable` and `pready` are 1 and `pwrite` is 0. Values on `prdata` at any other edge, including wait cycles and idle or setup cycles with `pready` high, never reach `rd_data`.
- R7: After the completion edge, the block is in IDLE on the next cycle, with `psel` and `penable` at 0 and `req_ready` at 1.
- R8: `rd_done` is 1 for exactly the one cycle that follows the completion edge. In that cycle `rd_data` equals the `prdata` value sampled at that edge.
- R9: Between completions, `rd_data` holds the value from the most recent completed read (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client requests a read |
| req_addr | input | ADDR_W | Address of the requested read |
| req_ready | output | 1 | High in IDLE; a request is taken when both are high |
| psel | output | 1 | Bus select |
| penable | output | 1 | Bus access-phase enable |
| pwrite | output | 1 | Bus direction, always 0 (read) |
| paddr | output | ADDR_W | Bus address, held for the whole transfer |
| prdata | input | DATA_W | Bus read data from the responder |
| pready | input | 1 | Responder ready; low inserts wait cycles |
| rd_data | output | DATA_W | Result register |
| rd_done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The timing is fixed relative to the clock edge at which each input is sampled:
- `req_ready` falls and SETUP appears one cycle after the accepting edge.
- `penable` rises one cycle after that.
- `rd_done` and the new `rd_data` appear one cycle after the edge where `pready` is sampled high in ACCESS.
- `psel` and `penable` are low in that same cycle.

The bench keeps a behavioural model that advances on every rising edge from the same inputs the design samples. It compares all outputs on the falling edge that follows, so every expected value is checked in the exact cycle it is due.

The bench's responder drives fresh random junk on `prdata` during wait cycles, idle cycles and setup cycles, and toggles `pready` randomly outside ACCESS. Any early or stray capture therefore shows up as a mismatch on `rd_data` in the next cycle.

// File: rtl/apb_rd_pkg.sv
package apb_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } rd_phase_e;

endpackage

// File: rtl/rd_phase_fsm.sv
module rd_phase_fsm
    import apb_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pready,
    output logic idle,
    output logic accept,
    output logic sel,
    output logic enable
);

    rd_phase_e state_q;
    rd_phase_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (start) state_d = PH_SETUP;
            PH_SETUP:  state_d = PH_ACCESS;
            PH_ACCESS: if (pready) state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle   = 1'b0;
        sel    = 1'b0;
        enable = 1'b0;
        unique case (state_q)
            PH_IDLE:   idle = 1'b1;
            PH_SETUP:  sel  = 1'b1;
            PH_ACCESS: begin
                sel    = 1'b1;
                enable = 1'b1;
            end
            default: idle = 1'b0;
        endcase
    end

    assign accept = idle & start;

    AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !enable) |=> (sel && enable)); // R3

    AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && enable && !pready) |=> (sel && enable)); // R4

    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && enable && pready) |=> (idle && !sel && !enable)); // R7

endmodule

// File: rtl/rd_addr_hold.sv
module rd_addr_hold #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= addr_in;
        end
    end

endmodule

// File: rtl/rd_data_capture.sv
module rd_data_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              ready,
    input  logic              write,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] result_q,
    output logic              done_q
);

    logic commit;

    // full handshake term, never the access phase alone
    assign commit = sel & enable & ready & ~write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= commit;
            if (commit) begin
                result_q <= bus_data;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && enable && ready) |=> $stable(result_q)); // R6

endmodule

// File: rtl/apb_rd_capture.sv
module apb_rd_capture
    import apb_rd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    logic take;

    assign pwrite = 1'b0;

    rd_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (req_valid),
        .pready (pready),
        .idle   (req_ready),
        .accept (take),
        .sel    (psel),
        .enable (penable)
    );

    rd_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .addr_in (req_addr),
        .addr_q  (paddr)
    );

    rd_data_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (psel),
        .enable   (penable),
        .ready    (pready),
        .write    (pwrite),
        .bus_data (prdata),
        .result_q (rd_data),
        .done_q   (rd_done)
    );

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> $stable(paddr)); // R5

    AST_ACCEPT_TO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (psel && !penable && !req_ready)); // R2

endmodule

// File: tb/tb_apb_rd_capture.sv
module tb_apb_rd_capture;

    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] prdata = '0;
    logic          pready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_done;

    apb_rd_capture #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .prdata(prdata), .pready(pready),
        .rd_data(rd_data), .rd_done(rd_done)
    );

    always #2 clk = ~clk; // 250 MHz

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int wait_left = 0;
    int reads_done = 0;

    // behavioural reference: 0 idle, 1 setup, 2 access
    int            m_ph = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    bit            m_done = 1'b0;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) + 32'h0000_1234;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_addr = '0; m_data = '0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            case (m_ph)
                0: if (req_valid) begin m_ph = 1; m_addr = req_addr; end
                1: m_ph = 2;
                default: if (pready) begin
                    m_data = prdata; m_done = 1'b1; m_ph = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        // compare
        if (!rst_n) begin
            chk("R1 rd_data in reset", rd_data, '0);
            chk("R1 psel in reset", DW'(psel), '0);
        end
        chk("R2 req_ready", DW'(req_ready), DW'(m_ph == 0));
        chk("R3/R7 psel", DW'(psel), DW'(m_ph != 0));
        chk("R3/R4 penable", DW'(penable), DW'(m_ph == 2));
        chk("R5 pwrite", DW'(pwrite), '0);
        if (m_ph != 0) chk("R5 paddr", DW'(paddr), DW'(m_addr));
        chk("R8 rd_done", DW'(rd_done), DW'(m_done));
        chk("R6/R9 rd_data", rd_data, m_data);
        if (m_done) reads_done++;

        // reset control
        if (cyc == 3)    rst_n = 1'b1;
        if (cyc == 1500) rst_n = 1'b0;
        if (cyc == 1503) rst_n = 1'b1;

        // client: requests arrive often, also while busy (R2)
        req_valid = (($urandom % 3) != 0);
        req_addr  = AW'($urandom);

        // responder with random waits and junk data (R6)
        if (psel && !penable) begin
            wait_left = $urandom % 6;
            pready = 1'($urandom % 2);
            prdata = $urandom;
        end else if (psel && penable) begin
            if (wait_left > 0) begin
                wait_left--;
                pready = 1'b0;
                prdata = $urandom;
            end else begin
                pready = 1'b1;
                prdata = mem_val(paddr);
            end
        end else begin
            pready = 1'($urandom % 2);
            prdata = $urandom;
        end

        if (cyc == 3000) begin
            if (reads_done < 50) begin
                n_bad++;
                $display("FAIL R8 too few completions: actual %0d expected >= 50", reads_done);
            end
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL R7 watchdog expired: actual cycle %0d expected 3000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule